// File: doc/BRIEF.md
# BCD Calendar and Time-of-Day Counter

This block keeps the time of day and the calendar date as a chain of two-digit BCD counters. Every field advances only on clock edges where a once-per-second tick enable is high. Seconds and minutes roll over at 60, hours at 24, and the day field rolls over at the length of the current month. That length depends on the month and, for February, on whether the current year is a leap year. The month wraps from 12 to 01 and carries into a four-digit BCD year.

A load strobe writes a complete date and time in one clock. A loaded day larger than the length of the loaded month is clamped to that length. The block exposes every field as packed BCD, with the tens digit in the upper nibble, and a flag that is high while the current year is a leap year. Clock division and display drive sit outside the block.

Top module: `bcd_calendar`

## Requirements
- R1: A synchronous reset sets the time to 00:00:00 and the date to day 01, month 01, year 2000.
- R2: On an edge with tick and load both low, every output keeps its value.
- R3: Seconds and minutes each count 00 to 59. On the tick that wraps a field from 59 to 00, the next higher field advances on the same edge.
- R4: Hours count 00 to 23. A wrap from 23 to 00 advances the day on the same edge.
- R5: Months 01, 03, 05, 07, 08, 10 and 12 run through day 31 before the day returns to 01.
- R6: Months 04, 06, 09 and 11 run through day 30 before the day returns to 01.
- R7: February runs through day 29 in a leap year and through day 28 otherwise.
- R8: The leap output is high when the year is divisible by 4 and not by 100, or when it is divisible by 400. The year is given as four BCD digits, thousands in bits 15:12 down to units in bits 3:0.
- R9: When the day wraps, the month advances. A wrap from month 12 to 01 advances the year. Year 9999 is followed by 0000.
- R10: A load strobe writes all six fields from the load ports on that edge, and takes priority over the tick.
- R11: A loaded day above the length of the loaded month and year is stored as that length.
- R12: In every field the units digit goes from 9 to 0 and increments the tens digit, so no nibble ever holds a value above 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Advance-by-one-second enable |
| load | input | 1 | Write all fields from the load ports |
| ld_sec | input | 8 | Seconds to load, BCD |
| ld_min | input | 8 | Minutes to load, BCD |
| ld_hour | input | 8 | Hours to load, BCD |
| ld_day | input | 8 | Day to load, BCD |
| ld_month | input | 8 | Month to load, BCD |
| ld_year | input | 16 | Year to load, four BCD digits |
| sec_o | output | 8 | Current seconds, BCD |
| min_o | output | 8 | Current minutes, BCD |
| hour_o | output | 8 | Current hours, BCD |
| day_o | output | 8 | Current day, BCD |
| month_o | output | 8 | Current month, BCD |
| year_o | output | 16 | Current year, four BCD digits |
| leap_o | output | 1 | Current year is a leap year |

## Verification
A long run of ticks from reset exercises the digit, minute and hour carries. It separates a units-digit fault from a tens-digit fault and from a missing cascade. Loads placed a few seconds before midnight on the last day of February in 2023, 2024, 2100 and 2000 tell the plain divisible-by-4 rule apart from the century exceptions. The end of April and the end of December, including 9999, check the 30-day limit, the month wrap and the year carry. Idle cycles and over-long loaded days confirm that nothing moves without a tick and that the day is clamped to the month length.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef logic [7:0]  bcd2_t;
    typedef logic [15:0] bcd4_t;

    // two-digit BCD increment, no limit handling
    function automatic bcd2_t bcd2_inc(input bcd2_t v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // is a two-digit BCD number a multiple of four
    function automatic logic bcd2_div4(input bcd2_t v);
        if (v[4])
            return (v[3:0] == 4'd2) || (v[3:0] == 4'd6);
        else
            return (v[3:0] == 4'd0) || (v[3:0] == 4'd4) || (v[3:0] == 4'd8);
    endfunction

    // Gregorian leap rule on four BCD digits
    function automatic logic bcd_leap(input bcd4_t y);
        if (y[7:0] == 8'h00)
            return bcd2_div4(y[15:8]);
        else
            return bcd2_div4(y[7:0]);
    endfunction

    // last day of a month, BCD
    function automatic bcd2_t bcd_month_len(input bcd2_t m, input logic leap);
        case (m)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_month_limit.sv
module cal_month_limit
    import cal_pkg::*;
(
    input  bcd2_t month,
    input  bcd4_t year,
    output bcd2_t last_day,
    output logic  leap
);
    always_comb begin
        leap     = bcd_leap(year);
        last_day = bcd_month_len(month, leap);
    end
endmodule

// File: rtl/cal_digit_pair.sv
module cal_digit_pair
    import cal_pkg::*;
#(
    parameter bcd2_t FIRST   = 8'h00,
    parameter bcd2_t RST_VAL = 8'h00
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    input  bcd2_t last,
    input  logic  load,
    input  bcd2_t load_val,
    output bcd2_t value,
    output logic  wrap
);
    assign wrap = step && (value == last);

    always_ff @(posedge clk) begin
        if (rst)
            value <= RST_VAL;
        else if (load)
            value <= load_val;
        else if (step)
            value <= wrap ? FIRST : bcd2_inc(value);
    end

    // R12: a stepped pair never leaves a nibble above 9
    assert_bcd_nibbles_R12: assert property (@(posedge clk) disable iff (rst)
        (step && !load && value[3:0] <= 4'd9 && value[7:4] <= 4'd9)
        |=> (value[3:0] <= 4'd9 && value[7:4] <= 4'd9));

    // R3: a step at the limit returns the pair to its first value
    assert_wrap_first_R3: assert property (@(posedge clk) disable iff (rst)
        (step && !load && value == last) |=> (value == FIRST));
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import cal_pkg::*;
#(
    parameter bcd4_t RST_YEAR = 16'h2000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        load,
    input  logic [7:0]  ld_sec,
    input  logic [7:0]  ld_min,
    input  logic [7:0]  ld_hour,
    input  logic [7:0]  ld_day,
    input  logic [7:0]  ld_month,
    input  logic [15:0] ld_year,
    output logic [7:0]  sec_o,
    output logic [7:0]  min_o,
    output logic [7:0]  hour_o,
    output logic [7:0]  day_o,
    output logic [7:0]  month_o,
    output logic [15:0] year_o,
    output logic        leap_o
);
    localparam int NPAIR = 7;   // sec, min, hour, day, month, year lo, year hi

    typedef struct packed {
        bcd2_t first;
        bcd2_t rst_val;
    } pair_cfg_t;

    function automatic pair_cfg_t cfg_of(input int i);
        case (i)
            3, 4:    return '{first: 8'h01, rst_val: 8'h01};
            5:       return '{first: 8'h00, rst_val: RST_YEAR[7:0]};
            6:       return '{first: 8'h00, rst_val: RST_YEAR[15:8]};
            default: return '{first: 8'h00, rst_val: 8'h00};
        endcase
    endfunction

    bcd2_t cur_last, ld_last, ld_day_c;
    logic  cur_leap, ld_leap;

    bcd2_t val   [NPAIR];
    bcd2_t lim   [NPAIR];
    bcd2_t ldv   [NPAIR];
    logic  stp   [NPAIR];
    logic  wrp   [NPAIR];

    cal_month_limit u_cur_lim (
        .month(val[4]), .year({val[6], val[5]}),
        .last_day(cur_last), .leap(cur_leap)
    );

    cal_month_limit u_ld_lim (
        .month(ld_month), .year(ld_year),
        .last_day(ld_last), .leap(ld_leap)
    );

    // clamp a loaded day to its month length; leap of load only feeds the limit
    assign ld_day_c = (ld_day > ld_last) ? ld_last : ld_day;

    always_comb begin
        lim[0] = 8'h59;  lim[1] = 8'h59;  lim[2] = 8'h23;
        lim[3] = cur_last; lim[4] = 8'h12;
        lim[5] = 8'h99;  lim[6] = 8'h99;
        ldv[0] = ld_sec; ldv[1] = ld_min; ldv[2] = ld_hour;
        ldv[3] = ld_day_c; ldv[4] = ld_month;
        ldv[5] = ld_year[7:0]; ldv[6] = ld_year[15:8];
        stp[0] = tick;
        for (int k = 1; k < NPAIR; k++) stp[k] = wrp[k-1];
    end

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        localparam pair_cfg_t CFG = cfg_of(g);
        cal_digit_pair #(.FIRST(CFG.first), .RST_VAL(CFG.rst_val)) u_pair (
            .clk(clk), .rst(rst), .step(stp[g]), .last(lim[g]),
            .load(load), .load_val(ldv[g]),
            .value(val[g]), .wrap(wrp[g])
        );
    end

    assign sec_o   = val[0];
    assign min_o   = val[1];
    assign hour_o  = val[2];
    assign day_o   = val[3];
    assign month_o = val[4];
    assign year_o  = {val[6], val[5]};
    assign leap_o  = cur_leap;

    // R2: idle edges change nothing
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o)
                              && $stable(day_o) && $stable(month_o) && $stable(year_o)));

    // R9: a day wrap returns the day to 01 and moves the month
    assert_month_follows_day_R9: assert property (@(posedge clk) disable iff (rst)
        (wrp[3] && !load) |=> (day_o == 8'h01 && month_o != $past(month_o)));

    // R11: a loaded day never exceeds the month length
    assert_load_clamp_R11: assert property (@(posedge clk) disable iff (rst)
        load |=> (day_o <= cur_last));

    // R7: last day of a non-leap February steps into March
    assert_feb_short_R7: assert property (@(posedge clk) disable iff (rst)
        (wrp[2] && !load && month_o == 8'h02 && day_o == 8'h28 && !leap_o)
        |=> (month_o == 8'h03 && day_o == 8'h01));

    // R8: leap flag reflects the year digits
    assert_leap_rule_R8: assert property (@(posedge clk) disable iff (rst)
        (year_o == 16'h2000) |-> leap_o);

    logic unused_ld_leap;
    assign unused_ld_leap = ld_leap;
endmodule

// File: tb/tb_bcd_calendar.sv
`timescale 1ns/1ps
module tb_bcd_calendar;
    logic clk = 1'b0;
    logic rst, tick, load;
    logic [7:0]  ld_sec, ld_min, ld_hour, ld_day, ld_month;
    logic [15:0] ld_year;
    logic [7:0]  sec_o, min_o, hour_o, day_o, month_o;
    logic [15:0] year_o;
    logic        leap_o;

    always #5 clk = ~clk;

    bcd_calendar dut (
        .clk(clk), .rst(rst), .tick(tick), .load(load),
        .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour),
        .ld_day(ld_day), .ld_month(ld_month), .ld_year(ld_year),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .day_o(day_o),
        .month_o(month_o), .year_o(year_o), .leap_o(leap_o)
    );

    int total = 0, bad = 0;
    bit done = 0;
    int m_s, m_mi, m_h, m_d, m_mo, m_y;

    function automatic logic [7:0] bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction
    function automatic logic [15:0] bcd4(input int v);
        return {bcd(v / 100), bcd(v % 100)};
    endfunction
    function automatic bit is_leap(input int y);
        return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
    endfunction
    function automatic int dim(input int mo, input int y);
        if (mo == 2) return is_leap(y) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_all(input string ctx);
        check({"R3 sec ", ctx},   16'(sec_o),   16'(bcd(m_s)));
        check({"R3 min ", ctx},   16'(min_o),   16'(bcd(m_mi)));
        check({"R4 hour ", ctx},  16'(hour_o),  16'(bcd(m_h)));
        check({"R5 R6 R7 day ", ctx}, 16'(day_o), 16'(bcd(m_d)));
        check({"R9 month ", ctx}, 16'(month_o), 16'(bcd(m_mo)));
        check({"R9 year ", ctx},  year_o,       bcd4(m_y));
        check({"R8 leap ", ctx},  16'(leap_o),  16'(is_leap(m_y)));
    endtask

    task automatic advance();
        m_s++;
        if (m_s == 60) begin
            m_s = 0; m_mi++;
            if (m_mi == 60) begin
                m_mi = 0; m_h++;
                if (m_h == 24) begin
                    m_h = 0; m_d++;
                    if (m_d > dim(m_mo, m_y)) begin
                        m_d = 1; m_mo++;
                        if (m_mo == 13) begin
                            m_mo = 1; m_y = (m_y + 1) % 10000;
                        end
                    end
                end
            end
        end
    endtask

    // one clock: inputs set at negedge, model updated at the edge, compared at next negedge
    task automatic step(input logic t, input logic l, input string ctx);
        tick = t; load = l;
        @(posedge clk);
        if (l) begin
            m_s = (ld_sec[7:4] * 10) + ld_sec[3:0];
            m_mi = (ld_min[7:4] * 10) + ld_min[3:0];
            m_h = (ld_hour[7:4] * 10) + ld_hour[3:0];
            m_mo = (ld_month[7:4] * 10) + ld_month[3:0];
            m_y = ld_year[15:12] * 1000 + ld_year[11:8] * 100 + ld_year[7:4] * 10 + ld_year[3:0];
            m_d = (ld_day[7:4] * 10) + ld_day[3:0];
            if (m_d > dim(m_mo, m_y)) m_d = dim(m_mo, m_y);
        end else if (t) begin
            advance();
        end
        @(negedge clk);
        compare_all(ctx);
        tick = 0; load = 0;
    endtask

    task automatic do_load(input int y, input int mo, input int d,
                           input int h, input int mi, input int s, input bit with_tick);
        ld_year = bcd4(y); ld_month = bcd(mo); ld_day = bcd(d);
        ld_hour = bcd(h); ld_min = bcd(mi); ld_sec = bcd(s);
        step(with_tick, 1'b1, "R10 load");
    endtask

    task automatic ticks(input int n, input string ctx);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, ctx);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; tick = 0; load = 0;
        ld_sec = 0; ld_min = 0; ld_hour = 0; ld_day = 8'h01; ld_month = 8'h01; ld_year = 16'h2000;
        @(negedge clk); @(negedge clk);
        rst = 0;
        m_s = 0; m_mi = 0; m_h = 0; m_d = 1; m_mo = 1; m_y = 2000;
        compare_all("R1 reset");
        check("R1 reset year", year_o, 16'h2000);

        // R12: units digit 9 -> 0 carries into tens
        ticks(10, "R12");
        check("R12 sec tens carry", 16'(sec_o), 16'h0010);

        // R2: idle cycles
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, "R2 idle");
        check("R2 hold sec", 16'(sec_o), 16'h0010);

        // R3 R4: minute and hour carries
        ticks(3700, "R3 R4 run");

        // R7 non-leap Feb 28 -> Mar 1
        do_load(2023, 2, 28, 23, 59, 58, 0);
        ticks(3, "R7 2023");
        check("R7 2023 month", 16'(month_o), 16'h0003);

        // R7 leap Feb 29 reached and left
        do_load(2024, 2, 28, 23, 59, 59, 0);
        ticks(1, "R7 2024 to 29");
        check("R7 2024 day 29", 16'(day_o), 16'h0029);
        do_load(2024, 2, 29, 23, 59, 59, 0);
        ticks(2, "R7 2024 to Mar");

        // R8 century rules
        do_load(2100, 2, 28, 23, 59, 59, 0);
        check("R8 2100 not leap", 16'(leap_o), 16'h0000);
        ticks(1, "R8 2100");
        do_load(2000, 2, 28, 23, 59, 59, 0);
        check("R8 2000 leap", 16'(leap_o), 16'h0001);
        ticks(1, "R8 2000");

        // R6 Apr 30 -> May 1
        do_load(2023, 4, 30, 23, 59, 58, 0);
        ticks(3, "R6 April");
        check("R6 May 1", 16'(month_o), 16'h0005);

        // R5 Jan 31 -> Feb 1
        do_load(2023, 1, 31, 23, 59, 59, 0);
        ticks(1, "R5 January");

        // R9 Dec 31 23:59:59 -> Jan 1 and year carry
        do_load(1999, 12, 31, 23, 59, 58, 0);
        ticks(2, "R9 year end");
        check("R9 year 2000", year_o, 16'h2000);
        do_load(9999, 12, 31, 23, 59, 59, 0);
        ticks(1, "R9 9999");
        check("R9 year wrap 0000", year_o, 16'h0000);

        // R10 load wins over tick
        do_load(2031, 7, 15, 12, 34, 56, 1);
        check("R10 load over tick", 16'(sec_o), 16'h0056);

        // R11 clamp
        do_load(2023, 4, 31, 1, 2, 3, 0);
        check("R11 clamp April", 16'(day_o), 16'h0030);
        do_load(2023, 2, 30, 1, 2, 3, 0);
        check("R11 clamp Feb", 16'(day_o), 16'h0028);
        do_load(2024, 2, 31, 1, 2, 3, 0);
        check("R11 clamp leap Feb", 16'(day_o), 16'h0029);

        // R1 reset again mid-run
        rst = 1; @(negedge clk); rst = 0;
        m_s = 0; m_mi = 0; m_h = 0; m_d = 1; m_mo = 1; m_y = 2000;
        compare_all("R1 second reset");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule